// File: doc/BRIEF.md
# Serial DAC Register Front End

This block is the serial slave side of a 20-bit converter. A host talks to it in fixed 24-bit frames over an active-low frame select, a serial clock that idles high and a serial data input, and can read registers back on a serial data output. Each frame carries a read/write flag, a register address and twenty data bits. The block keeps the converter code, a control word and a clear code. A write to a dedicated action address does not store anything and instead fires one-cycle action pulses.

All serial inputs are brought into the system clock domain through a multi-flop synchronizer. Serial clock edges are then detected there, so every parallel output is already in the system clock domain. To read a register, the host sends a read frame. It then sends a second frame, normally a no-operation, during which the requested word comes out on the serial output.

Top module: `spi_dac_if`

## Requirements
- R1: After reset the converter code, control word and clear code are zero, all three action pulses are low and the serial output is 0.
- R2: A frame is shifted in most significant bit first. Serial input is sampled on each falling serial clock edge while frame select is low. Bit 23 is the read/write flag (0 = write, 1 = read), bits 22:20 are the address and bits 19:0 are the data.
- R3: A write to address 1 loads the converter code, a write to address 2 loads the control word and a write to address 3 loads the clear code. The other two registers keep their values.
- R4: A frame takes effect only at the rising edge of frame select, and only if exactly 24 falling clock edges were seen while it was low. A frame with any other count changes no register and fires no pulse.
- R5: Writes to address 0 (no-operation) and to addresses 5, 6 and 7 change no register and fire no pulse.
- R6: A write to address 4 stores nothing. Data bit 0 fires the load pulse. Data bit 1 fires the clear pulse and copies the clear code into the converter code. Data bit 2 fires the soft-reset pulse and zeroes all three registers, and it takes precedence over the clear copy.
- R7: A read to address 1, 2 or 3 leaves all registers unchanged. It queues the word {1, address, register value} for output. During the next frame that word comes out MSB first: bit 23 is on the serial output before the first falling edge, and the output advances after each rising edge.
- R8: A read to address 0, 4, 5, 6 or 7 queues an all-zero word. Once a queued word has been shifted out, or when no read was made, the serial output gives 0.
- R9: Each action pulse is high for exactly one system clock cycle for each action write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idle high |
| sdin | input | 1 | Serial data in |
| sdo | output | 1 | Serial readback data out |
| dac_code | output | 20 | Converter code register |
| ctrl_word | output | 20 | Control register |
| clear_code | output | 20 | Clear-code register |
| load_pulse | output | 1 | One-cycle load action |
| clear_pulse | output | 1 | One-cycle clear action |
| reset_pulse | output | 1 | One-cycle soft-reset action |

## Verification
On every cycle the assertions check the following: pulses last one cycle, the clear pulse coincides with the converter code equal to the clear code, the soft-reset pulse coincides with all registers at zero, and nothing changes while frame select has been low for a while. Only the bench scenarios can show the rest. That covers the field layout and bit order, the address decode, the discarding of short and long frames, and the word returned by a read one frame later, all against a model of the registers in the bench.

// File: rtl/spi_dac_pkg.sv
package spi_dac_pkg;

   localparam int unsigned MAP_ADDR_W = 3;

   typedef enum logic [MAP_ADDR_W-1:0] {
      ADR_NOP   = 3'd0,
      ADR_CODE  = 3'd1,
      ADR_CTRL  = 3'd2,
      ADR_CLEAR = 3'd3,
      ADR_ACT   = 3'd4
   } reg_addr_e;

   localparam int unsigned ACT_LOAD_BIT  = 0;
   localparam int unsigned ACT_CLEAR_BIT = 1;
   localparam int unsigned ACT_RESET_BIT = 2;

endpackage

// File: rtl/spi_dac_sync.sv
module spi_dac_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (STAGES >= 2) else $error("spi_dac_sync: STAGES must be at least 2");
   end

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
         end
         assign q[b] = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_dac_shifter.sv
module spi_dac_shifter #(
   parameter int unsigned FRAME_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n_s,
   input  logic               sclk_s,
   input  logic               sdin_s,
   input  logic               load_en,
   input  logic [FRAME_W-1:0] load_word,
   output logic               frame_done,
   output logic [FRAME_W-1:0] frame_word,
   output logic               sdo
);

   localparam int unsigned CNT_MAX = FRAME_W + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   logic               cs_q, sclk_q;
   logic [FRAME_W-1:0] in_sr, out_sr;
   logic [CNT_W-1:0]   bit_cnt;
   logic               active, sclk_fall, sclk_rise, cs_rise;

   assign active    = ~cs_n_s;
   assign sclk_fall = active & sclk_q & ~sclk_s;
   assign sclk_rise = active & ~sclk_q & sclk_s;
   assign cs_rise   = cs_n_s & ~cs_q;

   assign frame_done = cs_rise & (bit_cnt == CNT_W'(FRAME_W));
   assign frame_word = in_sr;
   assign sdo        = out_sr[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b1;
      end else begin
         cs_q   <= cs_n_s;
         sclk_q <= sclk_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_sr   <= '0;
         bit_cnt <= '0;
      end else if (cs_n_s && cs_q) begin
         bit_cnt <= '0;
      end else if (sclk_fall) begin
         in_sr <= {in_sr[FRAME_W-2:0], sdin_s};
         if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         out_sr <= '0;
      else if (load_en)   out_sr <= load_word;
      else if (sclk_rise) out_sr <= {out_sr[FRAME_W-2:0], 1'b0};
   end

endmodule

// File: rtl/spi_dac_regs.sv
module spi_dac_regs
   import spi_dac_pkg::*;
#(
   parameter int unsigned DATA_W  = 20,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned FRAME_W = 1 + ADDR_W + DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_done,
   input  logic [FRAME_W-1:0] frame_word,
   output logic               rd_load,
   output logic [FRAME_W-1:0] rd_word,
   output logic [DATA_W-1:0]  dac_code,
   output logic [DATA_W-1:0]  ctrl_word,
   output logic [DATA_W-1:0]  clear_code,
   output logic               load_pulse,
   output logic               clear_pulse,
   output logic               reset_pulse
);

   logic              rw;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] data;
   logic              wr, hit_code, hit_ctrl, hit_clear, hit_act;
   logic              do_load, do_clear, do_reset;

   assign rw   = frame_word[FRAME_W-1];
   assign addr = frame_word[FRAME_W-2 -: ADDR_W];
   assign data = frame_word[DATA_W-1:0];

   assign hit_code  = (addr == ADDR_W'(ADR_CODE));
   assign hit_ctrl  = (addr == ADDR_W'(ADR_CTRL));
   assign hit_clear = (addr == ADDR_W'(ADR_CLEAR));
   assign hit_act   = (addr == ADDR_W'(ADR_ACT));

   assign wr       = frame_done & ~rw;
   assign rd_load  = frame_done & rw;
   assign do_load  = wr & hit_act & data[ACT_LOAD_BIT];
   assign do_clear = wr & hit_act & data[ACT_CLEAR_BIT];
   assign do_reset = wr & hit_act & data[ACT_RESET_BIT];

   always_comb begin
      rd_word = '0;
      if (hit_code)  rd_word = {1'b1, addr, dac_code};
      if (hit_ctrl)  rd_word = {1'b1, addr, ctrl_word};
      if (hit_clear) rd_word = {1'b1, addr, clear_code};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_code   <= '0;
         ctrl_word  <= '0;
         clear_code <= '0;
      end else if (do_reset) begin
         dac_code   <= '0;
         ctrl_word  <= '0;
         clear_code <= '0;
      end else if (do_clear) begin
         dac_code <= clear_code;
      end else if (wr) begin
         if (hit_code)  dac_code   <= data;
         if (hit_ctrl)  ctrl_word  <= data;
         if (hit_clear) clear_code <= data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_pulse  <= 1'b0;
         clear_pulse <= 1'b0;
         reset_pulse <= 1'b0;
      end else begin
         load_pulse  <= do_load;
         clear_pulse <= do_clear;
         reset_pulse <= do_reset;
      end
   end

endmodule

// File: rtl/spi_dac_if.sv
module spi_dac_if
   import spi_dac_pkg::*;
#(
   parameter int unsigned DATA_W      = 20,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdin,
   output logic              sdo,
   output logic [DATA_W-1:0] dac_code,
   output logic [DATA_W-1:0] ctrl_word,
   output logic [DATA_W-1:0] clear_code,
   output logic              load_pulse,
   output logic              clear_pulse,
   output logic              reset_pulse
);

   localparam int unsigned FRAME_W = 1 + ADDR_W + DATA_W;

   initial begin
      assert (ADDR_W >= MAP_ADDR_W) else $error("spi_dac_if: ADDR_W too small for address map");
      assert (DATA_W > ACT_RESET_BIT) else $error("spi_dac_if: DATA_W too small for action bits");
      assert (SYNC_STAGES >= 2) else $error("spi_dac_if: SYNC_STAGES must be at least 2");
   end

   logic [2:0]         pins_s;
   logic               frame_done, rd_load;
   logic [FRAME_W-1:0] frame_word, rd_word;

   spi_dac_sync #(
      .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)
   ) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({cs_n, sclk, sdin}),
      .q(pins_s)
   );

   spi_dac_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]), .sdin_s(pins_s[0]),
      .load_en(rd_load), .load_word(rd_word),
      .frame_done(frame_done), .frame_word(frame_word),
      .sdo(sdo)
   );

   spi_dac_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .frame_done(frame_done), .frame_word(frame_word),
      .rd_load(rd_load), .rd_word(rd_word),
      .dac_code(dac_code), .ctrl_word(ctrl_word), .clear_code(clear_code),
      .load_pulse(load_pulse), .clear_pulse(clear_pulse), .reset_pulse(reset_pulse)
   );

endmodule

// File: rtl/spi_dac_checker.sv
module spi_dac_checker #(
   parameter int unsigned DATA_W      = 20,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              sclk,
   input logic              sdin,
   input logic              sdo,
   input logic [DATA_W-1:0] dac_code,
   input logic [DATA_W-1:0] ctrl_word,
   input logic [DATA_W-1:0] clear_code,
   input logic              load_pulse,
   input logic              clear_pulse,
   input logic              reset_pulse
);

   localparam int unsigned LIM   = SYNC_STAGES + 4;
   localparam int unsigned LCN_W = $clog2(LIM + 1);

   logic [LCN_W-1:0] low_cnt;
   logic             unused_ok;

   assign unused_ok = sclk ^ sdin ^ sdo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       low_cnt <= '0;
      else if (cs_n)                    low_cnt <= '0;
      else if (low_cnt != LCN_W'(LIM))  low_cnt <= low_cnt + 1'b1;
   end

   AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |=> !load_pulse); // R9
   AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      clear_pulse |=> !clear_pulse); // R9
   AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      reset_pulse |=> !reset_pulse); // R9
   AST_CLEAR_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_pulse && !reset_pulse) |-> (dac_code == clear_code)); // R6
   AST_SOFT_RESET_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      reset_pulse |-> (dac_code == '0 && ctrl_word == '0 && clear_code == '0)); // R6
   AST_QUIET_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (low_cnt == LCN_W'(LIM)) |-> ($stable(dac_code) && $stable(ctrl_word)
         && $stable(clear_code) && !load_pulse && !clear_pulse && !reset_pulse)); // R4

endmodule

bind spi_dac_if spi_dac_checker #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/tb_spi_dac_if.sv
module tb_spi_dac_if;

   localparam int HALF = 6;

   logic clk = 0, rst_n = 0, cs_n = 1, sclk = 1, sdin = 0;
   logic sdo, load_pulse, clear_pulse, reset_pulse;
   logic [19:0] dac_code, ctrl_word, clear_code;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [19:0] m_dac = 0, m_ctrl = 0, m_clr = 0;
   int n_load = 0, n_clear = 0, n_reset = 0;
   int r_load = 0, r_clear = 0, r_reset = 0, wide = 0;

   always #2.5 clk = ~clk;

   spi_dac_if dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin), .sdo(sdo),
      .dac_code(dac_code), .ctrl_word(ctrl_word), .clear_code(clear_code),
      .load_pulse(load_pulse), .clear_pulse(clear_pulse), .reset_pulse(reset_pulse)
   );

   always @(negedge clk) begin
      if (load_pulse)  begin n_load++;  r_load++;  end else r_load = 0;
      if (clear_pulse) begin n_clear++; r_clear++; end else r_clear = 0;
      if (reset_pulse) begin n_reset++; r_reset++; end else r_reset = 0;
      if (r_load > 1 || r_clear > 1 || r_reset > 1) wide++;
   end

   task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic regs(string tag);
      chk({tag, " code"},  {4'h0, dac_code},   {4'h0, m_dac});
      chk({tag, " ctrl"},  {4'h0, ctrl_word},  {4'h0, m_ctrl});
      chk({tag, " clear"}, {4'h0, clear_code}, {4'h0, m_clr});
   endtask

   task automatic frame(input logic [23:0] w, input int nbits, output logic [23:0] rd);
      rd = '0;
      @(negedge clk) cs_n = 0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdin = (i < 24) ? w[23-i] : 1'b1;
         repeat (HALF) @(negedge clk);
         if (i < 24) rd = {rd[22:0], sdo};
         sclk = 0;
         repeat (HALF) @(negedge clk);
         sclk = 1;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1;
      repeat (3 * HALF) @(negedge clk);
   endtask

   function automatic logic [23:0] mk(bit r, logic [2:0] a, logic [19:0] d);
      return {r, a, d};
   endfunction

   task automatic wr(logic [2:0] a, logic [19:0] d);
      logic [23:0] junk;
      frame(mk(0, a, d), 24, junk);
      if (a == 1) m_dac = d;
      if (a == 2) m_ctrl = d;
      if (a == 3) m_clr = d;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [23:0] rd;
      repeat (4) @(negedge clk);
      chk("R1 sdo in reset", {23'h0, sdo}, 24'h0);
      rst_n = 1;
      repeat (4) @(negedge clk);
      regs("R1 after reset");
      chk("R1 pulses", {21'h0, load_pulse, clear_pulse, reset_pulse}, 24'h0);
      chk("R1 sdo", {23'h0, sdo}, 24'h0);

      // R3 each register, others unchanged
      wr(1, 20'hA5C3F); regs("R3 code write");
      wr(2, 20'h1234B); regs("R3 ctrl write");
      wr(3, 20'hF0E1D); regs("R3 clear write");

      // R2 walking bit shows MSB-first order and field position
      for (int b = 0; b < 20; b++) begin
         wr(1, 20'h1 << b);
         chk("R2 walking bit", {4'h0, dac_code}, {4'h0, m_dac});
      end
      wr(1, 20'h5AA5A); regs("R2 mixed pattern");

      // R5 NOP and unmapped writes ignored
      foreach (rd[i]) begin end
      for (int a = 0; a < 8; a++) begin
         if (a == 0 || a > 4) begin
            wr(a[2:0], 20'hFFFFF);
            regs("R5 ignored write");
         end
      end
      chk("R5 no pulse", n_load + n_clear + n_reset, 0);

      // R4 wrong bit counts discarded
      frame(mk(0, 1, 20'h00001), 23, rd); regs("R4 23 bits");
      frame(mk(0, 2, 20'h00002), 25, rd); regs("R4 25 bits");
      frame(mk(0, 3, 20'h00003), 0, rd);  regs("R4 0 bits");
      frame(mk(0, 4, 20'h00007), 23, rd);
      chk("R4 no action pulse", n_load + n_clear + n_reset, 0);

      // R7 readback of mapped registers, next frame
      for (int a = 1; a < 4; a++) begin
         logic [19:0] v;
         v = (a == 1) ? m_dac : (a == 2) ? m_ctrl : m_clr;
         frame(mk(1, a[2:0], 20'h0), 24, rd);
         regs("R7 read leaves regs");
         frame(mk(0, 0, 20'h0), 24, rd);
         chk("R7 readback word", rd, mk(1, a[2:0], v));
      end
      // R7 read word reflects latest value
      wr(2, 20'h0C0DE);
      frame(mk(1, 2, 20'h0), 24, rd);
      frame(mk(1, 1, 20'h0), 24, rd);
      chk("R7 chained read ctrl", rd, mk(1, 2, 20'h0C0DE));
      frame(mk(0, 0, 20'h0), 24, rd);
      chk("R7 chained read code", rd, mk(1, 1, m_dac));

      // R8 unmapped reads and idle output
      for (int a = 0; a < 8; a++) begin
         if (a == 0 || a > 3) begin
            frame(mk(1, a[2:0], 20'hFFFFF), 24, rd);
            frame(mk(0, 0, 20'h0), 24, rd);
            chk("R8 unmapped read", rd, 24'h0);
         end
      end
      frame(mk(0, 0, 20'h0), 24, rd);
      chk("R8 no pending read", rd, 24'h0);
      chk("R8 sdo idle", {23'h0, sdo}, 24'h0);

      // R6 action writes
      wr(4, 20'h00001);
      chk("R6 load pulse", n_load, 1);
      regs("R6 load keeps regs");
      wr(3, 20'h77777);
      wr(4, 20'h00002);
      m_dac = m_clr;
      chk("R6 clear pulse", n_clear, 1);
      regs("R6 clear copies");
      frame(mk(1, 4, 20'h0), 24, rd);
      frame(mk(0, 0, 20'h0), 24, rd);
      chk("R6 action not stored", rd, 24'h0);
      wr(1, 20'h13579);
      wr(4, 20'h00007);
      m_dac = 0; m_ctrl = 0; m_clr = 0;
      chk("R6 combined load", n_load, 2);
      chk("R6 combined clear", n_clear, 2);
      chk("R6 reset pulse", n_reset, 1);
      regs("R6 reset zeroes");
      chk("R9 single-cycle pulses", wide, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule